// File: doc/BRIEF.md
# Character Dot Pattern Generator

This block converts an 8-bit character code and a row index into the 5 dots of one row of a 5x8 glyph. The dots of a row are what a display refresh engine shifts into its segment latches. Most codes are served by a fixed glyph ROM. The lowest sixteen codes are served instead by a small writable RAM that holds eight user glyphs, so that software can define its own symbols. The ROM here holds generated placeholder content. Only the way that content is selected and windowed is defined.

The display side presents a code and a row on any cycle and receives the dots one cycle later. The host side loads and reads RAM rows through a request port. The RAM has a single access path, so a cycle in which the display fetches belongs to the display, and any cycle without a fetch is a host slot. A host request that meets a fetch is parked and carried out in the next free slot. The fetch therefore always sees a consistent RAM. Each RAM word is 8 bits wide. Only the low 5 bits are shown, and the upper 3 bits act as plain storage for the host.

A 2-bit span selector sets how much of the ROM is active. Codes beyond the active span produce blank rows.

Top module: `chargen_top`

## Requirements
- R1: After reset, fetch_ready, host_busy and host_rvalid are 0, and every user RAM word reads as 0.
- R2: fetch_ready is 1 in exactly the cycle after a cycle with fetch_valid high. In that cycle fetch_dots holds the row for the code and row presented with fetch_valid.
- R3: A code of 0x10 or above that lies below the active span returns dots = code[4:0] ^ {row[2:0],2'b00} ^ {2'b00,code[7:5]}.
- R4: rom_span_sel selects the active span: 0 gives 240 codes, 1 gives 248, 2 gives 250 and 3 gives 256. A code at or above the span returns 5'b00000.
- R5: Codes 0x00 to 0x0F return bits [4:0] of RAM word {code[2:0],row[2:0]}, so codes 0x08 to 0x0F alias codes 0x00 to 0x07.
- R6: A host_req in a cycle without fetch_valid, while host_busy is low, is performed at that clock edge, and host_busy stays low.
- R7: A host_req in a cycle with fetch_valid is held. host_busy is 1 from the next cycle until the request is carried out at the first edge of a cycle without fetch_valid, and it is 0 after that edge. A fetch in the same cycle as the request sees the RAM contents from before the write.
- R8: host_req is ignored while host_busy is 1.
- R9: A host read (host_we = 0) raises host_rvalid in the cycle after it is carried out. host_rdata then holds all 8 bits of the word, including the 3 bits that are not displayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rom_span_sel | input | 2 | Active ROM span select |
| fetch_valid | input | 1 | Display fetch request; claims this cycle |
| fetch_code | input | 8 | Character code to fetch |
| fetch_row | input | 3 | Glyph row 0..7 |
| fetch_ready | output | 1 | fetch_dots valid |
| fetch_dots | output | 5 | Dot pattern of the row |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 6 | RAM word address {glyph, row} |
| host_wdata | input | 8 | Write data |
| host_busy | output | 1 | A parked request is pending |
| host_rvalid | output | 1 | host_rdata valid |
| host_rdata | output | 8 | Read data |

## Verification
Some properties are checked on every cycle by the assertions. These cover the one-cycle fetch latency, the rule that a parked request holds host_busy through fetch cycles and clears it in the first free slot, and the rule that read data follows only a fetch-free cycle. Blank rows above the active span are also checked for every code presented. Other behaviour shows up only in the bench scenarios, which compare against a model of the RAM contents. These cover the actual pattern values, the aliasing of user glyphs, the persistence of the three hidden storage bits, and the fact that a fetch colliding with a write sees the old row.

// File: rtl/chargen_pkg.sv
package chargen_pkg;

   typedef enum logic [1:0] {
      SRC_ROM   = 2'd0,
      SRC_USER  = 2'd1,
      SRC_BLANK = 2'd2
   } dot_src_e;

   // number of active ROM codes for each span selection
   function automatic logic [8:0] span_limit(input logic [1:0] sel);
      case (sel)
         2'd0:    span_limit = 9'd240;
         2'd1:    span_limit = 9'd248;
         2'd2:    span_limit = 9'd250;
         default: span_limit = 9'd256;
      endcase
   endfunction

endpackage

// File: rtl/chargen_rom.sv
module chargen_rom #(
   parameter int CODE_W = 8,
   parameter int ROW_W  = 3,
   parameter int DOT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code,
   input  logic [ROW_W-1:0]  row,
   output logic [DOT_W-1:0]  dots
);
   localparam int HI_W = CODE_W - DOT_W;

   logic [DOT_W-1:0] pattern;

   // Generated placeholder artwork: low code bits, shifted row, high code bits.
   always_comb begin
      pattern = code[DOT_W-1:0];
      pattern = pattern ^ DOT_W'({row, 2'b00});
      pattern = pattern ^ DOT_W'(code[CODE_W-1:DOT_W]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dots <= '0;
      else        dots <= pattern;
   end

   if (HI_W < 1) begin : g_bad_hi
      $error("chargen_rom: CODE_W must exceed DOT_W");
   end
endmodule

// File: rtl/chargen_uram.sv
module chargen_uram #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] words [DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            words[gi] <= '0;
         else if (en && we && (addr == ADDR_W'(gi)))
            words[gi] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q <= '0;
      else if (en && !we)  q <= words[addr];
   end
endmodule

// File: rtl/chargen_arb.sv
module chargen_arb #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_valid,
   input  logic              host_req,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic              grant,
   output logic              op_we,
   output logic [ADDR_W-1:0] op_addr,
   output logic [DATA_W-1:0] op_wdata,
   output logic              host_busy,
   output logic              host_rvalid
);
   logic              park_q;
   logic              park_we_q;
   logic [ADDR_W-1:0] park_addr_q;
   logic [DATA_W-1:0] park_wdata_q;
   logic              accept;

   assign accept   = host_req && !park_q;
   assign grant    = !fetch_valid && (park_q || accept);
   assign op_we    = park_q ? park_we_q    : host_we;
   assign op_addr  = park_q ? park_addr_q  : host_addr;
   assign op_wdata = park_q ? park_wdata_q : host_wdata;
   assign host_busy = park_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         park_q       <= 1'b0;
         park_we_q    <= 1'b0;
         park_addr_q  <= '0;
         park_wdata_q <= '0;
         host_rvalid  <= 1'b0;
      end else begin
         host_rvalid <= grant && !op_we;
         if (grant) begin
            park_q <= 1'b0;
         end else if (accept) begin
            park_q       <= 1'b1;
            park_we_q    <= host_we;
            park_addr_q  <= host_addr;
            park_wdata_q <= host_wdata;
         end
      end
   end

   // R7: a parked request survives every fetch cycle
   p_busy_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      host_busy && fetch_valid |=> host_busy);
   // R7: a parked request is served in the first free slot
   p_busy_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
      host_busy && !fetch_valid |=> !host_busy);
   // R6: an immediate request never raises busy
   p_no_park_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !host_busy && host_req && !fetch_valid |=> !host_busy);
   // R9: read data only follows a fetch-free cycle
   p_rvalid_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      host_rvalid |-> $past(!fetch_valid));
endmodule

// File: rtl/chargen_top.sv
module chargen_top #(
   parameter int CODE_W      = 8,
   parameter int ROW_W       = 3,
   parameter int DOT_W       = 5,
   parameter int STORE_W     = 8,
   parameter int USER_GLYPHS = 8,
   parameter bit USER_ALIAS  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         rom_span_sel,
   input  logic               fetch_valid,
   input  logic [CODE_W-1:0]  fetch_code,
   input  logic [ROW_W-1:0]   fetch_row,
   output logic               fetch_ready,
   output logic [DOT_W-1:0]   fetch_dots,
   input  logic               host_req,
   input  logic               host_we,
   input  logic [$clog2(USER_GLYPHS)+ROW_W-1:0] host_addr,
   input  logic [STORE_W-1:0] host_wdata,
   output logic               host_busy,
   output logic               host_rvalid,
   output logic [STORE_W-1:0] host_rdata
);
   import chargen_pkg::*;

   localparam int GLYPH_W = $clog2(USER_GLYPHS);
   localparam int UADDR_W = GLYPH_W + ROW_W;
   localparam int USER_HI = USER_ALIAS ? GLYPH_W + 1 : GLYPH_W;

   logic               grant, op_we;
   logic [UADDR_W-1:0] op_addr, ram_addr;
   logic [STORE_W-1:0] op_wdata, ram_q;
   logic [DOT_W-1:0]   rom_dots;
   logic               user_hit, over_span;
   dot_src_e           src_d, src_q;

   if (USER_HI < CODE_W) begin : g_user_dec
      assign user_hit = (fetch_code[CODE_W-1:USER_HI] == '0);
   end else begin : g_user_all
      assign user_hit = 1'b1;
   end

   assign over_span = ({1'b0, fetch_code} >= (CODE_W+1)'(span_limit(rom_span_sel)));

   always_comb begin
      if (user_hit)       src_d = SRC_USER;
      else if (over_span) src_d = SRC_BLANK;
      else                src_d = SRC_ROM;
   end

   chargen_arb #(.ADDR_W(UADDR_W), .DATA_W(STORE_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid),
      .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .grant(grant), .op_we(op_we),
      .op_addr(op_addr), .op_wdata(op_wdata),
      .host_busy(host_busy), .host_rvalid(host_rvalid)
   );

   assign ram_addr = fetch_valid ? {fetch_code[GLYPH_W-1:0], fetch_row} : op_addr;

   chargen_uram #(.ADDR_W(UADDR_W), .DATA_W(STORE_W)) u_uram (
      .clk(clk), .rst_n(rst_n), .en(fetch_valid || grant),
      .we(grant && op_we && !fetch_valid), .addr(ram_addr),
      .wdata(op_wdata), .q(ram_q)
   );

   chargen_rom #(.CODE_W(CODE_W), .ROW_W(ROW_W), .DOT_W(DOT_W)) u_rom (
      .clk(clk), .rst_n(rst_n), .code(fetch_code), .row(fetch_row),
      .dots(rom_dots)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fetch_ready <= 1'b0;
         src_q       <= SRC_BLANK;
      end else begin
         fetch_ready <= fetch_valid;
         src_q       <= src_d;
      end
   end

   always_comb begin
      case (src_q)
         SRC_USER: fetch_dots = ram_q[DOT_W-1:0];
         SRC_ROM:  fetch_dots = rom_dots;
         default:  fetch_dots = '0;
      endcase
   end

   assign host_rdata = ram_q;

   if (DOT_W > STORE_W) begin : g_bad_store
      $error("chargen_top: STORE_W must hold DOT_W");
   end
   if ((1 << GLYPH_W) != USER_GLYPHS) begin : g_bad_glyphs
      $error("chargen_top: USER_GLYPHS must be a power of two");
   end
   if (CODE_W > 8) begin : g_bad_code
      $error("chargen_top: span limits assume CODE_W <= 8");
   end

   // R2: one-cycle fetch latency, both ways
   p_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid |=> fetch_ready);
   p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_valid |=> !fetch_ready);
   // R4: codes at or above the span return blank rows
   p_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid && (fetch_code[CODE_W-1:4] != '0) &&
      ({1'b0, fetch_code} >= (CODE_W+1)'(span_limit(rom_span_sel)))
      |=> (fetch_dots == '0));
endmodule

// File: tb/chargen_top_tb.sv
module chargen_top_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] rom_span_sel = 2'd0;
   logic       fetch_valid = 1'b0;
   logic [7:0] fetch_code = '0;
   logic [2:0] fetch_row = '0;
   logic       fetch_ready;
   logic [4:0] fetch_dots;
   logic       host_req = 1'b0, host_we = 1'b0;
   logic [5:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic       host_busy, host_rvalid;
   logic [7:0] host_rdata;

   int n_tests = 0, n_fail = 0;

   logic [7:0] m_mem [64];
   logic       m_pend = 1'b0, m_we = 1'b0;
   logic [5:0] m_addr = '0;
   logic [7:0] m_wdata = '0;

   always #5 clk = ~clk;

   chargen_top u_dut (
      .clk(clk), .rst_n(rst_n), .rom_span_sel(rom_span_sel),
      .fetch_valid(fetch_valid), .fetch_code(fetch_code), .fetch_row(fetch_row),
      .fetch_ready(fetch_ready), .fetch_dots(fetch_dots),
      .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_busy(host_busy),
      .host_rvalid(host_rvalid), .host_rdata(host_rdata)
   );

   function automatic int lim_of(input logic [1:0] s);
      case (s)
         2'd0: return 240;
         2'd1: return 248;
         2'd2: return 250;
         default: return 256;
      endcase
   endfunction

   function automatic logic [4:0] exp_dots(input logic [7:0] c, input logic [2:0] r,
                                          input logic [1:0] s);
      if (c < 8'h10) return m_mem[{c[2:0], r}][4:0];
      if (int'(c) >= lim_of(s)) return 5'b0;
      return c[4:0] ^ {r, 2'b00} ^ {2'b00, c[7:5]};
   endfunction

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // One cycle: drive at negedge, predict, check at the next negedge.
   task automatic step(input logic fv, input logic [7:0] c, input logic [2:0] r,
                       input logic rq, input logic w, input logic [5:0] a,
                       input logic [7:0] d);
      logic       acc, go, ow, e_rv;
      logic [5:0] oa;
      logic [7:0] od, e_rd;
      logic [4:0] e_dots;
      string      dtag, btag;
      fetch_valid = fv; fetch_code = c; fetch_row = r;
      host_req = rq; host_we = w; host_addr = a; host_wdata = d;
      e_dots = exp_dots(c, r, rom_span_sel);
      dtag = (c < 8'h10) ? "R5 user dots" :
             (int'(c) >= lim_of(rom_span_sel)) ? "R4 blank dots" : "R3 rom dots";
      btag = (rq && m_pend) ? "R8 busy" : (rq && !fv) ? "R6 busy" : "R7 busy";
      acc = rq && !m_pend;
      go  = !fv && (m_pend || acc);
      ow  = m_pend ? m_we : w;
      oa  = m_pend ? m_addr : a;
      od  = m_pend ? m_wdata : d;
      e_rv = go && !ow;
      e_rd = m_mem[oa];
      if (go && ow) m_mem[oa] = od;
      if (go) m_pend = 1'b0;
      else if (acc) begin
         m_pend = 1'b1; m_we = w; m_addr = a; m_wdata = d;
      end
      @(negedge clk);
      chk(fetch_ready == fv, "R2 ready", fetch_ready, fv);
      if (fv) chk(fetch_dots == e_dots, dtag, fetch_dots, e_dots);
      chk(host_busy == m_pend, btag, host_busy, m_pend);
      chk(host_rvalid == e_rv, "R9 rvalid", host_rvalid, e_rv);
      if (e_rv) chk(host_rdata == e_rd, "R9 rdata", host_rdata, e_rd);
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_c0de));
      for (int i = 0; i < 64; i++) m_mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(!fetch_ready && !host_busy && !host_rvalid, "R1 reset outputs",
          {fetch_ready, host_busy, host_rvalid}, 0);
      step(0, 0, 0, 1, 0, 6'd29, 0);            // R1: RAM read after reset is zero
      step(0, 0, 0, 0, 0, 0, 0);
      // R6 and R9: write then read back including hidden bits
      step(0, 0, 0, 1, 1, {3'd3, 3'd5}, 8'hEA);
      step(0, 0, 0, 1, 0, {3'd3, 3'd5}, 0);
      step(1, 8'h0B, 3'd5, 0, 0, 0, 0);          // R5 alias of glyph 3
      step(1, 8'h03, 3'd5, 0, 0, 0, 0);
      // R7: collision, fetch sees old row, write lands in first free slot
      step(1, 8'h03, 3'd5, 1, 1, {3'd3, 3'd5}, 8'h15);
      step(1, 8'h03, 3'd5, 1, 1, {3'd3, 3'd5}, 8'h1F); // R8 ignored while busy
      step(1, 8'h44, 3'd2, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0);
      step(1, 8'h03, 3'd5, 0, 0, 0, 0);
      step(0, 0, 0, 1, 0, {3'd3, 3'd5}, 0);
      // R4: span edges
      for (int s = 0; s < 4; s++) begin
         rom_span_sel = 2'(s);
         step(1, 8'hEF, 3'd1, 0, 0, 0, 0);
         step(1, 8'hF0, 3'd6, 0, 0, 0, 0);
         step(1, 8'hF7, 3'd3, 0, 0, 0, 0);
         step(1, 8'hF8, 3'd7, 0, 0, 0, 0);
         step(1, 8'hF9, 3'd0, 0, 0, 0, 0);
         step(1, 8'hFA, 3'd4, 0, 0, 0, 0);
         step(1, 8'hFF, 3'd2, 0, 0, 0, 0);
      end
      // R3 and mixed traffic: constrained random
      for (int i = 0; i < 4000; i++) begin
         logic [7:0] c;
         if (i % 64 == 0) rom_span_sel = 2'($urandom_range(0, 3));
         c = ($urandom_range(0, 2) == 0) ? 8'($urandom_range(0, 15)) : 8'($urandom);
         step(1'($urandom_range(0, 1)), c, 3'($urandom), ($urandom_range(0, 2) == 0),
              1'($urandom_range(0, 1)), 6'($urandom), 8'($urandom));
      end
      for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule